// File: doc/BRIEF.md
# YUV-to-RGB Pixel Converter

This block sits on a pixel-clocked video input path and turns each incoming sample into three 8-bit codes, red, green and blue, for downstream converters. It takes a 16-bit data word per clock. A 2-bit format field says how to read that word. In YUV 4:2:2 mode the upper byte is luma and the lower byte is chroma, with U and V samples taking turns. In packed RGB 5:6:5 mode the word holds three colour fields.

YUV samples pass through a fixed-point colour matrix with rounding and clamping. Chroma is read either as two's complement or as binary offset, as a control bit selects. 5:6:5 words skip the matrix, and each field is widened to 8 bits. A line-reference input marks active video. Its rising edge restarts the chroma U/V alternation. While it is low the outputs are black. The line reference is delayed along with the data, so the delayed copy lines up with the colour outputs.

Top module: `yuv_rgb_conv`

## Requirements
- R1: Latency is exactly 3 clocks. The data, format and line reference present before rising edge n appear on `r_o`, `g_o`, `b_o` and `active_o` after edge n+2. `active_o` is the line reference delayed by 3 clocks.
- R2: When the delayed line reference is low, `r_o`, `g_o` and `b_o` are all 0, whatever the data and format were.
- R3: With `fmt_i` = 2'b01 (RGB 5:6:5), red is `data_i[15:11]`, green is `data_i[10:5]` and blue is `data_i[4:0]`. Each field is widened to 8 bits by appending its own top bits: red and blue get their top 3 bits, green gets its top 2 bits.
- R4: With `fmt_i` equal to 2'b00, 2'b10 or 2'b11 (YUV 4:2:2), `data_i[15:8]` is luma Y and `data_i[7:0]` is the chroma sample.
- R5: With `chroma_offset_i` = 0 the chroma byte is read as a two's-complement signed value. With `chroma_offset_i` = 1 it is read as unsigned minus 128.
- R6: The first sample with the line reference high after it was low is U. Later samples alternate V, U, V and so on while the reference stays high. Each pixel uses its own Y and the most recent held U and V, including the sample taken on that clock. The held U and V reset to 0 and keep their values through blanking.
- R7: In YUV mode each output is within 1.5 LSB of the ideal result. R = 1.164(Y-16) + 1.596V, G = 1.164(Y-16) - 0.392U - 0.813V, B = 1.164(Y-16) + 2.017U, with the ideal result limited to 0..255.
- R8: Matrix results below 0 give output 0. Results above 255 give output 255.
- R9: While `rst_ni` is low, all outputs are 0 and `active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_ref_i | input | 1 | Line-active reference, high during active video |
| fmt_i | input | 2 | Input format: 2'b01 RGB 5:6:5, other values YUV 4:2:2 |
| chroma_offset_i | input | 1 | Chroma coding: 0 two's complement, 1 binary offset |
| data_i | input | 16 | Pixel word (Y and chroma, or packed 5:6:5) |
| r_o | output | 8 | Red code |
| g_o | output | 8 | Green code |
| b_o | output | 8 | Blue code |
| active_o | output | 1 | Line reference aligned with the outputs |

## Verification
Some properties are checked by assertions on every clock:
- the 3-clock alignment of `active_o`;
- black output whenever the delayed reference is low;
- exact field widening in 5:6:5 mode;
- the forced U phase on a line start.

Matrix accuracy, clamping at both ends, and both chroma codings can only be shown by the bench's scenarios. The same holds for U/V pairing across lines of odd length. The bench compares these results against a real-valued model of the conversion.

// File: rtl/yuv_rgb_pkg.sv
package yuv_rgb_pkg;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 10;
  localparam int FRAC_W = 7;
  localparam int SUM_W  = 20;
  localparam int RED_W  = 5;
  localparam int GRN_W  = 6;
  localparam int BLU_W  = 5;

  typedef enum logic [1:0] {
    FMT_YUV    = 2'b00,
    FMT_RGB565 = 2'b01,
    FMT_YUV_B  = 2'b10,
    FMT_YUV_C  = 2'b11
  } fmt_e;

  // matrix coefficients, scaled by 2**FRAC_W
  localparam logic signed [COEF_W-1:0] K_Y  = 10'sd149;
  localparam logic signed [COEF_W-1:0] K_RV = 10'sd204;
  localparam logic signed [COEF_W-1:0] K_GU = 10'sd50;
  localparam logic signed [COEF_W-1:0] K_GV = 10'sd104;
  localparam logic signed [COEF_W-1:0] K_BU = 10'sd258;
  localparam int Y_BLACK = 16;
endpackage

// File: rtl/yuv_rgb_input.sv
module yuv_rgb_input
  import yuv_rgb_pkg::*;
#(
  parameter int DW = PIX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_ref_i,
  input  logic [1:0]           fmt_i,
  input  logic                 chroma_offset_i,
  input  logic [2*DW-1:0]      data_i,
  output logic                 ref_o,
  output logic                 is565_o,
  output logic [2*DW-1:0]      word_o,
  output logic signed [DW-1:0] u_o,
  output logic signed [DW-1:0] v_o
);
  logic          ref_q, phase_v_q, line_start, take_u;
  logic [DW-1:0] c_s;

  always_comb begin
    // offset binary minus half-scale equals flipping the sign bit
    c_s        = chroma_offset_i ? {~data_i[DW-1], data_i[DW-2:0]} : data_i[DW-1:0];
    line_start = line_ref_i & ~ref_q;
    take_u     = line_start | ~phase_v_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q     <= 1'b0;
      phase_v_q <= 1'b0;
      is565_o   <= 1'b0;
      word_o    <= '0;
      u_o       <= '0;
      v_o       <= '0;
    end else begin
      ref_q   <= line_ref_i;
      is565_o <= (fmt_i == FMT_RGB565);
      word_o  <= data_i;
      if (line_ref_i) begin
        phase_v_q <= take_u;
        if (take_u) u_o <= c_s;
        else        v_o <= c_s;
      end
    end
  end

  assign ref_o = ref_q;

  assert_line_start_u_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_ref_i && !ref_q) |=> (phase_v_q && ref_q));
endmodule

// File: rtl/yuv_rgb_matrix.sv
module yuv_rgb_matrix
  import yuv_rgb_pkg::*;
#(
  parameter int DW   = PIX_W,
  parameter int SW   = SUM_W,
  parameter int FW   = FRAC_W,
  parameter int RW   = RED_W,
  parameter int GW   = GRN_W,
  parameter int BW   = BLU_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_i,
  input  logic                 is565_i,
  input  logic [2*DW-1:0]      word_i,
  input  logic signed [DW-1:0] u_i,
  input  logic signed [DW-1:0] v_i,
  output logic                 ref_o,
  output logic                 is565_o,
  output logic signed [SW-1:0] sum_r_o,
  output logic signed [SW-1:0] sum_g_o,
  output logic signed [SW-1:0] sum_b_o,
  output logic [DW-1:0]        pr_o,
  output logic [DW-1:0]        pg_o,
  output logic [DW-1:0]        pb_o
);
  localparam int G_LO = BW;
  localparam int R_LO = BW + GW;
  localparam logic signed [SW-1:0] RND = SW'(1) <<< (FW - 1);
  localparam logic signed [SW-1:0] CY  = SW'(K_Y);
  localparam logic signed [SW-1:0] CRV = SW'(K_RV);
  localparam logic signed [SW-1:0] CGU = SW'(K_GU);
  localparam logic signed [SW-1:0] CGV = SW'(K_GV);
  localparam logic signed [SW-1:0] CBU = SW'(K_BU);
  localparam logic signed [SW-1:0] YOF = SW'(Y_BLACK);

  logic signed [SW-1:0] ye, ue, ve, yt;
  logic [RW-1:0] rf;
  logic [GW-1:0] gf;
  logic [BW-1:0] bf;

  always_comb begin
    ye = $signed({{(SW-DW){1'b0}}, word_i[2*DW-1:DW]}) - YOF;
    ue = SW'(u_i);
    ve = SW'(v_i);
    yt = ye * CY + RND;
    rf = word_i[R_LO +: RW];
    gf = word_i[G_LO +: GW];
    bf = word_i[0 +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o   <= 1'b0;
      is565_o <= 1'b0;
      sum_r_o <= '0;
      sum_g_o <= '0;
      sum_b_o <= '0;
      pr_o    <= '0;
      pg_o    <= '0;
      pb_o    <= '0;
    end else begin
      ref_o   <= ref_i;
      is565_o <= is565_i;
      sum_r_o <= yt + ve * CRV;
      sum_g_o <= yt - ue * CGU - ve * CGV;
      sum_b_o <= yt + ue * CBU;
      // widen by repeating the field's top bits
      pr_o    <= {rf, rf[RW-1 -: DW-RW]};
      pg_o    <= {gf, gf[GW-1 -: DW-GW]};
      pb_o    <= {bf, bf[BW-1 -: DW-BW]};
    end
  end
endmodule

// File: rtl/yuv_rgb_output.sv
module yuv_rgb_output
  import yuv_rgb_pkg::*;
#(
  parameter int DW = PIX_W,
  parameter int SW = SUM_W,
  parameter int FW = FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ref_i,
  input  logic                 is565_i,
  input  logic signed [SW-1:0] sum_r_i,
  input  logic signed [SW-1:0] sum_g_i,
  input  logic signed [SW-1:0] sum_b_i,
  input  logic [DW-1:0]        pr_i,
  input  logic [DW-1:0]        pg_i,
  input  logic [DW-1:0]        pb_i,
  output logic [DW-1:0]        r_o,
  output logic [DW-1:0]        g_o,
  output logic [DW-1:0]        b_o,
  output logic                 active_o
);
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< DW) - SW'(1);

  function automatic logic [DW-1:0] clamp(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] sh;
    sh = s >>> FW;
    if (sh < 0)         return '0;
    else if (sh > MAXV) return '1;
    else                return sh[DW-1:0];
  endfunction

  logic [DW-1:0] r_n, g_n, b_n;

  always_comb begin
    if (!ref_i) begin
      r_n = '0; g_n = '0; b_n = '0;
    end else if (is565_i) begin
      r_n = pr_i; g_n = pg_i; b_n = pb_i;
    end else begin
      r_n = clamp(sum_r_i); g_n = clamp(sum_g_i); b_n = clamp(sum_b_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_o      <= '0;
      g_o      <= '0;
      b_o      <= '0;
      active_o <= 1'b0;
    end else begin
      r_o      <= r_n;
      g_o      <= g_n;
      b_o      <= b_n;
      active_o <= ref_i;
    end
  end
endmodule

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv
  import yuv_rgb_pkg::*;
#(
  parameter int DW = PIX_W,
  parameter int SW = SUM_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_ref_i,
  input  logic [1:0]    fmt_i,
  input  logic          chroma_offset_i,
  input  logic [2*DW-1:0] data_i,
  output logic [DW-1:0] r_o,
  output logic [DW-1:0] g_o,
  output logic [DW-1:0] b_o,
  output logic          active_o
);
  localparam int G_LO = BLU_W;
  localparam int R_LO = BLU_W + GRN_W;

  logic                 s1_ref, s1_565, s2_ref, s2_565;
  logic [2*DW-1:0]      s1_word;
  logic signed [DW-1:0] s1_u, s1_v;
  logic signed [SW-1:0] s2_r, s2_g, s2_b;
  logic [DW-1:0]        s2_pr, s2_pg, s2_pb;

  yuv_rgb_input #(.DW(DW)) u_in (
    .clk_i, .rst_ni, .line_ref_i, .fmt_i, .chroma_offset_i, .data_i,
    .ref_o(s1_ref), .is565_o(s1_565), .word_o(s1_word), .u_o(s1_u), .v_o(s1_v)
  );

  yuv_rgb_matrix #(.DW(DW), .SW(SW), .FW(FW)) u_mat (
    .clk_i, .rst_ni,
    .ref_i(s1_ref), .is565_i(s1_565), .word_i(s1_word), .u_i(s1_u), .v_i(s1_v),
    .ref_o(s2_ref), .is565_o(s2_565),
    .sum_r_o(s2_r), .sum_g_o(s2_g), .sum_b_o(s2_b),
    .pr_o(s2_pr), .pg_o(s2_pg), .pb_o(s2_pb)
  );

  yuv_rgb_output #(.DW(DW), .SW(SW), .FW(FW)) u_out (
    .clk_i, .rst_ni,
    .ref_i(s2_ref), .is565_i(s2_565),
    .sum_r_i(s2_r), .sum_g_i(s2_g), .sum_b_i(s2_b),
    .pr_i(s2_pr), .pg_i(s2_pg), .pb_i(s2_pb),
    .r_o, .g_o, .b_o, .active_o
  );

  // cycles since reset, so 3-deep history is valid
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_cnt <= '0;
    else if (warm_cnt != 3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (active_o == $past(line_ref_i, 3)));

  assert_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(line_ref_i, 3)) |-> (r_o == '0 && g_o == '0 && b_o == '0));

  assert_widen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(line_ref_i, 3) && ($past(fmt_i, 3) == FMT_RGB565)) |->
      (r_o == {$past(data_i[R_LO +: RED_W], 3), $past(data_i[2*DW-1 -: DW-RED_W], 3)} &&
       g_o == {$past(data_i[G_LO +: GRN_W], 3), $past(data_i[R_LO-1 -: DW-GRN_W], 3)} &&
       b_o == {$past(data_i[0 +: BLU_W], 3), $past(data_i[BLU_W-1 -: DW-BLU_W], 3)}));
endmodule

// File: tb/yuv_rgb_conv_test.sv
module yuv_rgb_conv_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_ref_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic        chroma_offset_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [7:0]  r_o, g_o, b_o;
  logic        active_o;

  yuv_rgb_conv uut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int    due;
    bit    act;
    bit    tol;
    int    r, g, b;
    string req;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cyc = 0;
  bit   m_prev = 0, m_phase_v = 0;
  int   m_u = 0, m_v = 0;
  bit   done = 0;

  function automatic int ideal(real x);
    if (x < 0.0) x = 0.0;
    if (x > 255.0) x = 255.0;
    return $rtoi(x * 1000.0 + 0.5);
  endfunction

  task automatic chk(string req, string nm, int act, int exp, bit tol);
    int d;
    total++;
    d = act * 1000 - exp;
    if (d < 0) d = -d;
    if (tol ? (d > 1500) : (d != 0)) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0.3f", req, nm, act, exp / 1000.0);
    end
  endtask

  task automatic drive(bit lr, logic [1:0] fmt, bit off, logic [15:0] d, string req);
    exp_t e;
    int   c;
    bit   take_u;
    real  yf;
    @(negedge clk_i);
    line_ref_i = lr; fmt_i = fmt; chroma_offset_i = off; data_i = d;
    c = off ? int'(d[7:0]) - 128 : int'($signed(d[7:0]));
    if (lr) begin
      take_u = !m_prev || !m_phase_v;
      if (take_u) m_u = c; else m_v = c;
      m_phase_v = take_u;
    end
    m_prev = lr;
    e.due = cyc + 3; e.act = lr; e.req = req; e.tol = 0;
    if (!lr) begin
      e.r = 0; e.g = 0; e.b = 0;
    end else if (fmt == 2'b01) begin
      e.r = 1000 * int'({d[15:11], d[15:13]});
      e.g = 1000 * int'({d[10:5], d[10:9]});
      e.b = 1000 * int'({d[4:0], d[4:2]});
    end else begin
      e.tol = 1;
      yf  = 1.164 * (real'(int'(d[15:8])) - 16.0);
      e.r = ideal(yf + 1.596 * m_v);
      e.g = ideal(yf - 0.392 * m_u - 0.813 * m_v);
      e.b = ideal(yf + 2.017 * m_u);
    end
    q.push_back(e);
  endtask

  // monitor: compare each expectation in its due cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        chk({e.req, "/R1"}, "active", int'(active_o), e.act ? 1000 : 0, 0);
        chk(e.req, "r", int'(r_o), e.r, e.tol);
        chk(e.req, "g", int'(g_o), e.g, e.tol);
        chk(e.req, "b", int'(b_o), e.b, e.tol);
      end
    end
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9", "r", int'(r_o), 0, 0);
    chk("R9", "g", int'(g_o), 0, 0);
    chk("R9", "b", int'(b_o), 0, 0);
    chk("R9", "active", int'(active_o), 0, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2: blanked input with busy data
    drive(0, 2'b00, 0, 16'hEB7F, "R2");
    drive(0, 2'b01, 0, 16'hFFFF, "R2");
    // R4 R5 R6 R7: two's complement chroma, odd-length line
    drive(1, 2'b00, 0, 16'h8010, "R6");
    drive(1, 2'b00, 0, 16'h80F0, "R6");
    drive(1, 2'b10, 0, 16'h5A30, "R4");
    drive(1, 2'b11, 0, 16'hC0C8, "R4");
    drive(1, 2'b00, 0, 16'h2000, "R7");
    drive(1, 2'b00, 0, 16'hA040, "R5");
    drive(1, 2'b00, 0, 16'h6B9C, "R7");
    drive(0, 2'b00, 0, 16'h1234, "R2");
    // R6: restart forces U even though phase was pending V
    drive(1, 2'b00, 0, 16'h7020, "R6");
    drive(1, 2'b00, 0, 16'h70E0, "R6");
    drive(0, 2'b00, 0, 16'h0000, "R2");
    // R5: binary offset chroma
    drive(1, 2'b00, 1, 16'h8080, "R5");
    drive(1, 2'b00, 1, 16'h80C0, "R5");
    drive(1, 2'b00, 1, 16'h4030, "R5");
    drive(1, 2'b00, 1, 16'hD0F0, "R5");
    drive(0, 2'b00, 1, 16'hFFFF, "R2");
    // R8: saturation at both ends
    drive(1, 2'b00, 0, 16'hFF7F, "R8");
    drive(1, 2'b00, 0, 16'hFF7F, "R8");
    drive(1, 2'b00, 0, 16'h0080, "R8");
    drive(1, 2'b00, 0, 16'h0080, "R8");
    drive(1, 2'b00, 0, 16'hEB00, "R8");
    // R3: 5:6:5 bypass
    drive(1, 2'b01, 0, 16'hFFFF, "R3");
    drive(1, 2'b01, 0, 16'h0000, "R3");
    drive(1, 2'b01, 0, 16'hF800, "R3");
    drive(1, 2'b01, 0, 16'h07E0, "R3");
    drive(1, 2'b01, 0, 16'h001F, "R3");
    drive(1, 2'b01, 1, 16'hA5A5, "R3");
    drive(1, 2'b01, 0, 16'h8421, "R3");
    drive(0, 2'b01, 0, 16'hFFFF, "R2");
    drive(0, 2'b01, 0, 16'hFFFF, "R2");
    for (int i = 0; i < 6; i++) drive(0, 2'b00, 0, 16'h0000, "R2");
    while (q.size() > 0) @(posedge clk_i);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule